// File: doc/BRIEF.md
# PCI Configuration Space Responder

This block is the type-0 configuration register file of a simple serial controller function. A configuration access port presents a dword index, a read strobe or a write strobe, four byte enables and write data. The block answers with read data one cycle later. It holds the fixed identification and class fields. It protects every read-only field. It keeps the values that system software programs into the I/O base address registers and the interrupt line.

The function decodes one or two 8-byte I/O windows. A strap input selects the dual-port variant, which enables the second window. Base address sizing follows the usual handshake: software writes all ones and reads back the size mask, with the I/O space indicator kept set. The programmed bases and the interrupt line go straight out to the downstream address decode. The strap must be stable whenever reset is released.

Top module: `pcfg_responder`

## Requirements
- R1: Dword 0 (byte offset 0x00) and dword 11 (offset 0x2C) both read 0x32534348, and writes to them have no effect.
- R2: Dword 1 (offset 0x04) reads 0x02000001: the command half 0x0001 is in bits 15:0 and the status half 0x0200 is in bits 31:16. Writes to it have no effect.
- R3: Dword 2 (offset 0x08) reads 0x07000210: revision 0x10 in bits 7:0, interface 0x02 in bits 15:8, subclass 0x00 in bits 23:16 and base class 0x07 in bits 31:24.
- R4: The first I/O base at dword 4 (offset 0x10) resets to 0x00000001. A write that is not a sizing write stores the byte-merged data with bits 1:0 kept from the previous value.
- R5: A write to an active I/O base with all four byte enables set and data 0xFFFFFFFF stores 0xFFFFFFF8 with bits 1:0 kept. A base that held 0x1 therefore reads 0xFFFFFFF9.
- R6: Byte enables act per lane: lanes whose enable is clear keep their old byte. 0xFF data in fewer than four lanes is an ordinary write and not a sizing write.
- R7: The second I/O base at dword 5 (offset 0x14) behaves as in R4 and R5 when the strap is 1, with reset value 0x00000001. When the strap is 0 it resets to zero and every write stores zero.
- R8: Dwords 6, 7 and 8 (offsets 0x18, 0x1C, 0x20) read zero whatever is written to them.
- R9: At dword 15 (offset 0x3C), bits 7:0 are the interrupt line: it resets to 0 and byte lane 0 can write it. Bits 15:8 read 0x01 and are write-protected. Bits 31:16 read zero.
- R10: The capability pointer at dword 13 (offset 0x34) reads zero. Every dword not named above reads zero, and writes to it are dropped.
- R11: The cycle after a read strobe, cfg_rvalid is 1 and cfg_rdata holds the addressed dword. A read in the same cycle as a write returns the value from before the write. With no read strobe, cfg_rvalid is 0 the next cycle.
- R12: io_base0, io_base1 and irq_line show the stored registers and change in the cycle after the write that updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dual_port_strap | input | 1 | 1 enables the second I/O window |
| cfg_rd | input | 1 | Read strobe |
| cfg_wr | input | 1 | Write strobe |
| cfg_addr | input | 6 | Dword index into configuration space |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| cfg_rdata | output | 32 | Read data |
| io_base0 | output | 32 | First I/O base register |
| io_base1 | output | 32 | Second I/O base register |
| irq_line | output | 8 | Interrupt line register |

## Verification
The main function is exercised with four kinds of base register write.

- A full-lane all-ones write separates sizing from an ordinary store.
- An aligned full-lane address shows that the indicator bits are kept.
- Partial-lane writes of 0xFF show that sizing needs all four lanes.
- A write that tries to clear bits 1:0 shows that they are protected.

Each constant dword, each forced-zero slot and several unimplemented slots are written with all ones and read back, to prove that nothing leaks through. The whole run is repeated with the strap low, to separate the single-port behaviour of the second base from the dual-port behaviour.

// File: rtl/pcfg_pkg.sv
// Shared constants and helpers for the configuration responder.
// Assumes dword addressing of a 256-byte configuration space.
package pcfg_pkg;
    localparam logic [31:0] ID_WORD      = 32'h3253_4348;
    localparam logic [15:0] CMD_VALUE    = 16'h0001;
    localparam logic [15:0] STAT_VALUE   = 16'h0200;
    localparam logic [7:0]  REV_ID       = 8'h10;
    localparam logic [7:0]  PROG_IF      = 8'h02;
    localparam logic [7:0]  SUB_CLASS    = 8'h00;
    localparam logic [7:0]  BASE_CLASS   = 8'h07;
    localparam logic [7:0]  INT_PIN_A    = 8'h01;

    localparam int DW_IDENT    = 0;
    localparam int DW_CMDSTAT  = 1;
    localparam int DW_CLASS    = 2;
    localparam int DW_BASE0    = 4;
    localparam int DW_SUBSYS   = 11;
    localparam int DW_CAPPTR   = 13;
    localparam int DW_INTR     = 15;

    // Merge new bytes into an old word, lane by lane, under byte enables.
    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be);
        logic [31:0] res;
        for (int b = 0; b < 4; b++)
            res[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        return res;
    endfunction
endpackage

// File: rtl/pcfg_ident_rom.sv
// Constant identification fields of the configuration header.
// Pure combinational lookup; hit is high for the dwords it owns.
module pcfg_ident_rom #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] dw_addr,
    output logic              hit,
    output logic [31:0]       data
);
    import pcfg_pkg::*;

    // Decode the constant dwords.
    always_comb begin
        hit  = 1'b1;
        data = '0;
        case (dw_addr)
            ADDR_W'(DW_IDENT):   data = ID_WORD;
            ADDR_W'(DW_SUBSYS):  data = ID_WORD;
            ADDR_W'(DW_CMDSTAT): data = {STAT_VALUE, CMD_VALUE};
            ADDR_W'(DW_CLASS):   data = {BASE_CLASS, SUB_CLASS, PROG_IF, REV_ID};
            ADDR_W'(DW_CAPPTR):  data = '0;
            default:             hit  = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcfg_io_bar.sv
// One I/O base address register with the sizing handshake.
// When present is low the register holds zero. A write of all ones on
// all lanes loads the window mask. Bits 1:0 are never changed by a write.
module pcfg_io_bar #(
    parameter int WIN_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        present,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic [3:0]  be,
    output logic [31:0] bar_q
);
    import pcfg_pkg::*;

    localparam logic [31:0] SIZE_MASK = ~(32'(WIN_BYTES) - 32'd1);

    logic [31:0] merged;
    logic        sizing;

    // Form the candidate value and detect a sizing write.
    always_comb begin
        merged = lane_merge(bar_q, wdata, be);
        sizing = (be == 4'hF) && (wdata == 32'hFFFF_FFFF);
    end

    // Hold the base; keep the space indicator bits across writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bar_q <= present ? 32'h0000_0001 : 32'h0;
        else if (wr_en) begin
            if (!present)
                bar_q <= '0;
            else if (sizing)
                bar_q <= {SIZE_MASK[31:2], bar_q[1:0]};
            else
                bar_q <= {merged[31:2], bar_q[1:0]};
        end
    end
endmodule

// File: rtl/pcfg_responder.sv
// Type-0 configuration register file for a serial controller function.
// Reads return one cycle after cfg_rd, with the values from before any
// same-cycle write. dual_port_strap must be stable whenever reset is released.
module pcfg_responder #(
    parameter int ADDR_W    = 6,
    parameter int WIN_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_port_strap,
    input  logic              cfg_rd,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic              cfg_rvalid,
    output logic [31:0]       cfg_rdata,
    output logic [31:0]       io_base0,
    output logic [31:0]       io_base1,
    output logic [7:0]        irq_line
);
    import pcfg_pkg::*;

    localparam int NUM_IO_BARS = 2;

    logic [31:0] bar_q [NUM_IO_BARS];
    logic        rom_hit;
    logic [31:0] rom_data;
    logic [31:0] rd_mux;

    pcfg_ident_rom #(.ADDR_W(ADDR_W)) u_rom (
        .dw_addr (cfg_addr),
        .hit     (rom_hit),
        .data    (rom_data)
    );

    for (genvar i = 0; i < NUM_IO_BARS; i++) begin : g_bar
        logic present_i;
        // The first window always exists; the second follows the strap.
        assign present_i = (i == 0) ? 1'b1 : dual_port_strap;
        pcfg_io_bar #(.WIN_BYTES(WIN_BYTES)) u_bar (
            .clk     (clk),
            .rst_n   (rst_n),
            .present (present_i),
            .wr_en   (cfg_wr && (cfg_addr == ADDR_W'(DW_BASE0 + i))),
            .wdata   (cfg_wdata),
            .be      (cfg_be),
            .bar_q   (bar_q[i])
        );
    end

    // Interrupt line byte: writable through lane 0 only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_line <= '0;
        else if (cfg_wr && cfg_addr == ADDR_W'(DW_INTR) && cfg_be[0])
            irq_line <= cfg_wdata[7:0];
    end

    // Select the read value for the addressed dword.
    always_comb begin
        if (rom_hit)
            rd_mux = rom_data;
        else if (cfg_addr == ADDR_W'(DW_BASE0))
            rd_mux = bar_q[0];
        else if (cfg_addr == ADDR_W'(DW_BASE0 + 1))
            rd_mux = bar_q[1];
        else if (cfg_addr == ADDR_W'(DW_INTR))
            rd_mux = {16'h0, INT_PIN_A, irq_line};
        else
            rd_mux = '0;
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= cfg_rd;
            if (cfg_rd)
                cfg_rdata <= rd_mux;
        end
    end

    assign io_base0 = bar_q[0];
    assign io_base1 = bar_q[1];
endmodule

// File: rtl/pcfg_responder_chk.sv
// Temporal checks on the responder ports, attached by bind.
module pcfg_responder_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dual_port_strap,
    input logic              cfg_rd,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic              cfg_rvalid,
    input logic [31:0]       cfg_rdata,
    input logic [31:0]       io_base0,
    input logic [31:0]       io_base1,
    input logic [7:0]        irq_line
);
    import pcfg_pkg::*;

    a_r11_rvalid_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |=> cfg_rvalid);

    a_r11_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |=> !cfg_rvalid);

    a_r4_io_indicator_kept: assert property (@(posedge clk) disable iff (!rst_n)
        io_base0[0] == 1'b1);

    a_r7_single_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_port_strap |-> io_base1 == 32'h0);

    a_r5_sizing_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == ADDR_W'(DW_BASE0) && cfg_be == 4'hF &&
         cfg_wdata == 32'hFFFF_FFFF) |=> io_base0[31:2] == 30'h3FFF_FFFE);

    a_r12_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_addr == ADDR_W'(DW_INTR) && cfg_be[0]) |=> $stable(irq_line));

    a_r2_cmdstat_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == ADDR_W'(DW_CMDSTAT)) |=> cfg_rdata == 32'h0200_0001);
endmodule

bind pcfg_responder pcfg_responder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .dual_port_strap (dual_port_strap),
    .cfg_rd          (cfg_rd),
    .cfg_wr          (cfg_wr),
    .cfg_addr        (cfg_addr),
    .cfg_be          (cfg_be),
    .cfg_wdata       (cfg_wdata),
    .cfg_rvalid      (cfg_rvalid),
    .cfg_rdata       (cfg_rdata),
    .io_base0        (io_base0),
    .io_base1        (io_base1),
    .irq_line        (irq_line)
);

// File: tb/test_pcfg_responder.sv
// Bench: behavioural reference model compared on every clock.
module test_pcfg_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b1;
    logic        cfg_rd = 1'b0, cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata, io_base0, io_base1;
    logic [7:0]  irq_line;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Reference state
    logic [31:0] m_b0, m_b1;
    logic [7:0]  m_irq;
    logic        m_rv;
    logic [31:0] m_rd;
    string       m_tag;

    always #10 clk = ~clk;

    pcfg_responder i_pcfg_responder (
        .clk(clk), .rst_n(rst_n), .dual_port_strap(strap),
        .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid),
        .cfg_rdata(cfg_rdata), .io_base0(io_base0), .io_base1(io_base1),
        .irq_line(irq_line)
    );

    function automatic string tag_of(input int a);
        case (a)
            0, 11:   return "R1";
            1:       return "R2";
            2:       return "R3";
            4:       return "R4";
            5:       return "R7";
            6, 7, 8: return "R8";
            15:      return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [31:0] model_read(input int a);
        case (a)
            0, 11: return 32'h3253_4348;
            1:     return 32'h0200_0001;
            2:     return 32'h0700_0210;
            4:     return m_b0;
            5:     return m_b1;
            15:    return {16'h0, 8'h01, m_irq};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] bar_next(input logic [31:0] old, input bit live,
                                             input logic [3:0] be, input logic [31:0] d);
        logic [31:0] v = old;
        if (!live) return 32'h0;
        if (be == 4'hF && d == 32'hFFFF_FFFF) v = 32'hFFFF_FFF8;
        else for (int k = 0; k < 4; k++) if (be[k]) v[8*k +: 8] = d[8*k +: 8];
        v[1:0] = old[1:0];
        return v;
    endfunction

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive, update the model at the edge, compare at the falling edge.
    task automatic step(input bit rd, input bit wr, input int a,
                        input logic [3:0] be, input logic [31:0] d, input string tag);
        cfg_rd = rd; cfg_wr = wr; cfg_addr = 6'(a); cfg_be = be; cfg_wdata = d;
        @(posedge clk);
        if (!rst_n) begin
            m_b0 = 32'h1; m_b1 = strap ? 32'h1 : 32'h0; m_irq = '0; m_rv = 0;
        end else begin
            m_rv = rd;
            if (rd) begin
                m_rd = model_read(a);
                m_tag = (tag != "") ? tag : tag_of(a);
            end
            if (wr && a == 4) m_b0 = bar_next(m_b0, 1, be, d);
            if (wr && a == 5) m_b1 = bar_next(m_b1, strap, be, d);
            if (wr && a == 15 && be[0]) m_irq = d[7:0];
        end
        @(negedge clk);
        cmp(32'(cfg_rvalid), 32'(m_rv), "R11");
        if (m_rv) cmp(cfg_rdata, m_rd, m_tag);
        cmp(io_base0, m_b0, "R12");
        cmp(io_base1, m_b1, "R7");
        cmp(32'(irq_line), 32'(m_irq), "R9");
    endtask

    task automatic rd_(input int a, input string tag);
        step(1, 0, a, 4'h0, 32'h0, tag);
    endtask
    task automatic wr_(input int a, input logic [3:0] be, input logic [31:0] d);
        step(0, 1, a, be, d, "");
    endtask

    task automatic run_phase(input bit s);
        @(negedge clk);
        strap = s; rst_n = 1'b0;
        step(0, 0, 0, 0, 0, ""); step(0, 0, 0, 0, 0, "");
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "");
        // constants and forced zeros, before and after all-ones writes (R1 R2 R3 R8 R10)
        for (int a = 0; a < 16; a++) rd_(a, "");
        rd_(63, "R10");
        for (int a = 0; a < 16; a++) if (a != 4 && a != 5 && a != 15) wr_(a, 4'hF, 32'hFFFF_FFFF);
        wr_(63, 4'hF, 32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) rd_(a, "");
        rd_(63, "R10");
        for (int b = 4; b <= 5; b++) begin
            wr_(b, 4'hF, 32'h0000_C000); rd_(b, "R4");
            wr_(b, 4'hF, 32'hFFFF_FFFF); rd_(b, "R5");
            wr_(b, 4'hF, 32'h0000_0000); rd_(b, "R4");
            wr_(b, 4'h2, 32'h0000_AB00); rd_(b, "R6");
            wr_(b, 4'h7, 32'hFFFF_FFFF); rd_(b, "R6");
            wr_(b, 4'hE, 32'hFFFF_FFFF); rd_(b, "R6");
            wr_(b, 4'hF, 32'hFFFF_FFFE); rd_(b, "R4");
        end
        // interrupt line: lane 0 only, pin protected (R9)
        wr_(15, 4'hF, 32'hFFFF_FFFF); rd_(15, "R9");
        wr_(15, 4'hE, 32'h0000_0055); rd_(15, "R9");
        wr_(15, 4'h1, 32'h0000_003C); rd_(15, "R9");
        // read and write together return the old value (R11)
        step(1, 1, 4, 4'hF, 32'h0000_E000, "R11");
        rd_(4, "R11");
        step(1, 1, 15, 4'h1, 32'h0000_0007, "R11");
        rd_(15, "R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        run_phase(1'b1);
        run_phase(1'b0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule